// File: doc/BRIEF.md
# Per-Slot Network Interrupt Aggregator

This block gathers per-port network interrupt requests from seven adapter slots and folds them into a single interrupt line toward the processor. Each slot has eight ports. Each slot owns one byte lane in one of two 32-bit status banks. The slot-to-lane assignment is fixed and irregular. Each bank has a matching 32-bit mask register. The output line is high whenever any status bit in either bank is also enabled by the mask bit of the same bank and position.

Requests arrive on two independent channels, a set channel and a clear channel. Each channel carries a slot number and a port number, and both channels may fire in the same cycle. Software sees the block through a simple register bus. The read data is a combinational function of the address. A write takes effect on the clock edge that samples it. Reads never change state.

Top module: `netirq_aggregator`

## Requirements
- R1: After a synchronous active-low reset, both status banks and both masks hold zero and `net_irq` is low.
- R2: The bank 0 byte lanes are assigned as follows: slot 0 takes bits 7:0, slot 1 takes bits 15:8, slot 4 takes bits 23:16 and slot 3 takes bits 31:24.
- R3: The bank 1 byte lanes are assigned as follows: slot 2 takes bits 15:8, slot 6 takes bits 23:16 and slot 5 takes bits 31:24. Bits 7:0 of bank 1 are never set.
- R4: A set request makes status bit (lane base + port) one. A clear request makes that bit zero. No other bit changes. Both take effect at the clock edge that samples the request.
- R5: When a set request and a clear request name the same slot and port in the same cycle, the bit ends up one.
- R6: `net_irq` is high exactly when (bank 0 status AND mask 0) or (bank 1 status AND mask 1) is nonzero. It follows any status or mask change in the same clock edge that makes the change.
- R7: A read at byte offsets 0x10 to 0x13 returns the whole bank 0 status word. A read at 0x18 to 0x1B returns the whole bank 1 status word. Reads leave all state unchanged.
- R8: Mask 0 is read and written at offset 0x20. Mask 1 is read and written at offset 0x28. A write stores the full 32-bit data word.
- R9: Writes to the status offsets (0x10 to 0x13 and 0x18 to 0x1B) change nothing.
- R10: Reads at any offset not listed in R7 or R8 return zero. Writes to such offsets change nothing.
- R11: A request whose slot number is 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| set_valid | input | 1 | Set request strobe |
| set_slot | input | 3 | Slot number of the set request |
| set_port | input | 3 | Port number of the set request |
| clr_valid | input | 1 | Clear request strobe |
| clr_slot | input | 3 | Slot number of the clear request |
| clr_port | input | 3 | Port number of the clear request |
| bus_addr | input | 8 | Register byte offset |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_data | output | 32 | Read data for `bus_addr`, combinational |
| net_irq | output | 1 | Combined network interrupt |

## Verification
A request or a mask write presented before a rising edge changes the status, the mask, `net_irq` and the read data right after that edge. There is exactly one register stage and no further delay. Read data depends on the address with no register stage, so it reflects the state present while the address is held. The bench drives every input on a falling edge. At the next falling edge, before it drives anything new, it compares `net_irq` and `bus_rd_data` with its model, which has already taken in the stimulus. Each comparison therefore lands half a cycle after the edge at which the result is due.

// File: rtl/netirq_pkg.sv
// Shared constants and the slot routing table for the network interrupt
// aggregator. Assumes two banks of 32 bits and eight ports per slot.
package netirq_pkg;
    localparam int NUM_SLOTS      = 7;
    localparam int PORTS_PER_SLOT = 8;
    localparam int NUM_BANKS      = 2;
    localparam int WORD_W         = 32;
    localparam int ADDR_W         = 8;
    localparam int SLOT_W         = 3;
    localparam int PORT_W         = $clog2(PORTS_PER_SLOT);
    localparam int BIT_W          = $clog2(WORD_W);
    localparam int BANK_W         = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int STAT_BASE      = 'h10;
    localparam int MASK_BASE      = 'h20;
    localparam int BANK_STRIDE    = 'h08;

    // Returns the status bank that holds a slot's lane.
    function automatic int unsigned route_bank(input logic [SLOT_W-1:0] slot);
        case (slot)
            3'd0, 3'd1, 3'd3, 3'd4: return 0;
            default:                return 1;
        endcase
    endfunction

    // Returns the byte lane index inside the bank for a slot.
    function automatic int unsigned route_lane(input logic [SLOT_W-1:0] slot);
        case (slot)
            3'd0:       return 0;
            3'd1, 3'd2: return 1;
            3'd4, 3'd6: return 2;
            3'd3, 3'd5: return 3;
            default:    return 0;
        endcase
    endfunction
endpackage

// File: rtl/netirq_route.sv
// Turns one slot/port request into a one-hot bit vector per bank.
// Assumes: slot numbers at or above NUM_SLOTS produce no bit at all.
module netirq_route
    import netirq_pkg::*;
(
    input  logic                              req_valid,
    input  logic [SLOT_W-1:0]                 req_slot,
    input  logic [PORT_W-1:0]                 req_port,
    output logic [NUM_BANKS-1:0][WORD_W-1:0]  bit_hit
);
    logic [BANK_W-1:0] bank_sel;
    logic [BIT_W-1:0]  bit_sel;

    // Map the request onto its bank and bit position.
    always_comb begin
        bit_hit  = '0;
        bank_sel = BANK_W'(route_bank(req_slot));
        bit_sel  = BIT_W'(route_lane(req_slot) * PORTS_PER_SLOT) + BIT_W'(req_port);
        if (req_valid && (int'(req_slot) < NUM_SLOTS)) begin
            bit_hit[bank_sel][bit_sel] = 1'b1;
        end
    end
endmodule

// File: rtl/netirq_status_bank.sv
// One status bank of pending network interrupts.
// Assumes: set and clear vectors arrive one-hot or zero; set overrides clear.
module netirq_status_bank
    import netirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_bits,
    input  logic [WORD_W-1:0] clr_bits,
    output logic [WORD_W-1:0] status
);
    // Apply clear first, then set, so a coincident set survives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= (status & ~clr_bits) | set_bits;
        end
    end
endmodule

// File: rtl/netirq_regs.sv
// Mask registers and read multiplexer of the aggregator.
// Assumes: status is read-only on the bus; unmapped offsets read zero.
module netirq_regs
    import netirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [WORD_W-1:0] bus_wr_data,
    input  logic [WORD_W-1:0] status_in [NUM_BANKS],
    output logic [WORD_W-1:0] mask_out  [NUM_BANKS],
    output logic [WORD_W-1:0] bus_rd_data
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mask
        localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(MASK_BASE + BANK_STRIDE * b);

        // Capture a full-word write to this bank's mask.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_out[b] <= '0;
            end else if (bus_wr_en && (bus_addr == MASK_ADDR)) begin
                mask_out[b] <= bus_wr_data;
            end
        end
    end

    logic [ADDR_W-1:0] stat_addr;
    logic [ADDR_W-1:0] mask_addr;

    // Select read data: status word by word address, mask by exact offset.
    always_comb begin
        bus_rd_data = '0;
        stat_addr   = '0;
        mask_addr   = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            stat_addr = ADDR_W'(STAT_BASE + BANK_STRIDE * b);
            mask_addr = ADDR_W'(MASK_BASE + BANK_STRIDE * b);
            if (bus_addr[ADDR_W-1:2] == stat_addr[ADDR_W-1:2]) begin
                bus_rd_data = status_in[b];
            end
            if (bus_addr == mask_addr) begin
                bus_rd_data = mask_out[b];
            end
        end
    end
endmodule

// File: rtl/netirq_aggregator.sv
// Top of the per-slot network interrupt aggregator: routes set/clear
// requests into status banks, holds masks, drives one interrupt line.
// Assumes: a single clock and a synchronous active-low reset.
module netirq_aggregator
    import netirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_valid,
    input  logic [2:0]        set_slot,
    input  logic [2:0]        set_port,
    input  logic              clr_valid,
    input  logic [2:0]        clr_slot,
    input  logic [2:0]        clr_port,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr_en,
    input  logic [31:0]       bus_wr_data,
    output logic [31:0]       bus_rd_data,
    output logic              net_irq
);
    logic [NUM_BANKS-1:0][WORD_W-1:0] set_hit;
    logic [NUM_BANKS-1:0][WORD_W-1:0] clr_hit;
    logic [WORD_W-1:0]                stat_q [NUM_BANKS];
    logic [WORD_W-1:0]                mask_q [NUM_BANKS];
    logic [WORD_W-1:0]                bank_status_0;
    logic [WORD_W-1:0]                bank_status_1;
    logic [WORD_W-1:0]                bank_mask_0;
    logic [WORD_W-1:0]                bank_mask_1;

    netirq_route u_set_route (
        .req_valid (set_valid),
        .req_slot  (set_slot),
        .req_port  (set_port),
        .bit_hit   (set_hit)
    );

    netirq_route u_clr_route (
        .req_valid (clr_valid),
        .req_slot  (clr_slot),
        .req_port  (clr_port),
        .bit_hit   (clr_hit)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        netirq_status_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_bits (set_hit[b]),
            .clr_bits (clr_hit[b]),
            .status   (stat_q[b])
        );
    end

    netirq_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr_en   (bus_wr_en),
        .bus_wr_data (bus_wr_data),
        .status_in   (stat_q),
        .mask_out    (mask_q),
        .bus_rd_data (bus_rd_data)
    );

    // Raise the interrupt when any bank has an enabled pending bit.
    always_comb begin
        net_irq = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            net_irq = net_irq | (|(stat_q[b] & mask_q[b]));
        end
    end

    // Flat views of the bank state for the bound checker.
    assign bank_status_0 = stat_q[0];
    assign bank_status_1 = stat_q[1];
    assign bank_mask_0   = mask_q[0];
    assign bank_mask_1   = mask_q[1];
endmodule

// File: rtl/netirq_aggregator_checker.sv
// Temporal checks on the aggregator, attached to the top by bind.
// Assumes: the bench holds reset low from time zero.
module netirq_aggregator_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        set_valid,
    input logic [2:0]  set_slot,
    input logic [2:0]  set_port,
    input logic        clr_valid,
    input logic [2:0]  clr_slot,
    input logic [2:0]  clr_port,
    input logic [7:0]  bus_addr,
    input logic        bus_wr_en,
    input logic [31:0] bus_wr_data,
    input logic        net_irq,
    input logic [31:0] st0,
    input logic [31:0] st1,
    input logic [31:0] mk0,
    input logic [31:0] mk1
);
    logic was_rst;

    // Remember that the previous edge was inside reset.
    always_ff @(posedge clk) was_rst <= !rst_n;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (st0 == 32'h0 && st1 == 32'h0 && mk0 == 32'h0 && mk1 == 32'h0 && !net_irq));

    assert_clear_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && !set_valid) |=> ($countones({st0, st1}) <= $past($countones({st0, st1}))));

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid && clr_valid && set_slot == clr_slot && set_port == clr_port && set_slot != 3'd7)
        |=> (({st0, st1} != 64'h0) && ($countones({st0, st1}) >= $past($countones({st0, st1})))));

    assert_irq_has_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        net_irq |-> (((st0 & mk0) != 32'h0) || ((st1 & mk1) != 32'h0)));

    assert_mask0_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == 8'h20) |=> (mk0 == $past(bus_wr_data)));

    assert_mask1_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == 8'h28) |=> (mk1 == $past(bus_wr_data)));

    assert_status_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && (bus_addr[7:2] == 6'h04 || bus_addr[7:2] == 6'h06) && !set_valid && !clr_valid)
        |=> ($stable(st0) && $stable(st1)));

    assert_bad_slot_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid && set_slot == 3'd7 && !clr_valid) |=> ($stable(st0) && $stable(st1)));
endmodule

bind netirq_aggregator netirq_aggregator_checker u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_valid   (set_valid),
    .set_slot    (set_slot),
    .set_port    (set_port),
    .clr_valid   (clr_valid),
    .clr_slot    (clr_slot),
    .clr_port    (clr_port),
    .bus_addr    (bus_addr),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_data (bus_wr_data),
    .net_irq     (net_irq),
    .st0         (bank_status_0),
    .st1         (bank_status_1),
    .mk0         (bank_mask_0),
    .mk1         (bank_mask_1)
);

// File: tb/netirq_aggregator_test.sv
module netirq_aggregator_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        set_valid, clr_valid, bus_wr_en;
    logic [2:0]  set_slot, set_port, clr_slot, clr_port;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wr_data, bus_rd_data;
    logic        net_irq;

    always #2 clk = ~clk;

    netirq_aggregator uut (
        .clk(clk), .rst_n(rst_n),
        .set_valid(set_valid), .set_slot(set_slot), .set_port(set_port),
        .clr_valid(clr_valid), .clr_slot(clr_slot), .clr_port(clr_port),
        .bus_addr(bus_addr), .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
        .bus_rd_data(bus_rd_data), .net_irq(net_irq)
    );

    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    string       pend_tag = "R1";
    int          bank_of [7] = '{0, 0, 1, 0, 0, 1, 1};
    int          lane_of [7] = '{0, 1, 1, 3, 2, 3, 2};
    logic [31:0] ms [2];
    logic [31:0] mm [2];
    logic [7:0]  addr_pool [12] = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h18, 8'h19,
                                    8'h1A, 8'h1B, 8'h20, 8'h28, 8'h24, 8'h00};

    function automatic logic [31:0] model_rd(input logic [7:0] a);
        if (a >= 8'h10 && a <= 8'h13) return ms[0];
        if (a >= 8'h18 && a <= 8'h1B) return ms[1];
        if (a == 8'h20) return mm[0];
        if (a == 8'h28) return mm[1];
        return 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called on a falling edge: compare outputs with the model.
    task automatic compare_now();
        logic exp_irq;
        exp_irq = ((ms[0] & mm[0]) != 0) || ((ms[1] & mm[1]) != 0);
        check(pend_tag, bus_rd_data, model_rd(bus_addr));
        check("R6", {31'h0, net_irq}, {31'h0, exp_irq});
    endtask

    // Compare, then drive one cycle of stimulus and advance the model.
    task automatic step(input bit sv, input logic [2:0] ss, input logic [2:0] sp,
                        input bit cv, input logic [2:0] cs, input logic [2:0] cp,
                        input bit we, input logic [7:0] a, input logic [31:0] wd,
                        input string tag);
        @(negedge clk);
        compare_now();
        set_valid = sv; set_slot = ss; set_port = sp;
        clr_valid = cv; clr_slot = cs; clr_port = cp;
        bus_wr_en = we; bus_addr = a; bus_wr_data = wd;
        if (cv && cs < 3'd7) ms[bank_of[cs]] &= ~(32'h1 << (lane_of[cs] * 8 + int'(cp)));
        if (sv && ss < 3'd7) ms[bank_of[ss]] |= (32'h1 << (lane_of[ss] * 8 + int'(sp)));
        if (we && a == 8'h20) mm[0] = wd;
        if (we && a == 8'h28) mm[1] = wd;
        pend_tag = tag;
    endtask

    task automatic idle(input logic [7:0] a, input string tag);
        step(0, 3'd0, 3'd0, 0, 3'd0, 3'd0, 0, a, 32'h0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        set_valid = 0; set_slot = 0; set_port = 0;
        clr_valid = 0; clr_slot = 0; clr_port = 0;
        bus_wr_en = 0; bus_addr = 8'h10; bus_wr_data = 0;
        ms[0] = 0; ms[1] = 0; mm[0] = 0; mm[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values on every mapped offset
        idle(8'h10, "R1"); idle(8'h18, "R1"); idle(8'h20, "R1"); idle(8'h28, "R1");
        idle(8'h10, "R1");

        // R2: bank 0 lanes, R3: bank 1 lanes
        step(1, 3'd0, 3'd1, 0, 0, 0, 0, 8'h10, 0, "R2");
        step(1, 3'd1, 3'd2, 0, 0, 0, 0, 8'h10, 0, "R2");
        step(1, 3'd3, 3'd7, 0, 0, 0, 0, 8'h10, 0, "R2");
        step(1, 3'd4, 3'd0, 0, 0, 0, 0, 8'h10, 0, "R2");
        step(1, 3'd2, 3'd3, 0, 0, 0, 0, 8'h18, 0, "R3");
        step(1, 3'd5, 3'd5, 0, 0, 0, 0, 8'h18, 0, "R3");
        step(1, 3'd6, 3'd6, 0, 0, 0, 0, 8'h18, 0, "R3");
        idle(8'h10, "R2");
        idle(8'h18, "R3");

        // R7: every status byte offset, repeated to show no side effect
        for (int k = 0; k < 2; k++) begin
            idle(8'h11, "R7"); idle(8'h12, "R7"); idle(8'h13, "R7");
            idle(8'h19, "R7"); idle(8'h1A, "R7"); idle(8'h1B, "R7");
        end

        // R8 and R6: masks enable the interrupt
        step(0, 0, 0, 0, 0, 0, 1, 8'h20, 32'h0000_0400, "R8");
        idle(8'h20, "R8");
        step(0, 0, 0, 0, 0, 0, 1, 8'h20, 32'h0, "R6");
        step(0, 0, 0, 0, 0, 0, 1, 8'h28, 32'h8000_0000, "R8");
        idle(8'h28, "R8");
        step(0, 0, 0, 0, 0, 0, 1, 8'h28, 32'hFFFF_FFFF, "R6");

        // R4: clear removes one bit only
        step(0, 0, 0, 1, 3'd5, 3'd5, 0, 8'h18, 0, "R4");
        step(0, 0, 0, 1, 3'd2, 3'd3, 0, 8'h18, 0, "R4");
        step(0, 0, 0, 1, 3'd6, 3'd6, 0, 8'h18, 0, "R4");
        idle(8'h18, "R4");

        // R5: set wins on the same bit; different bits act independently
        step(1, 3'd5, 3'd7, 1, 3'd5, 3'd7, 0, 8'h18, 0, "R5");
        step(1, 3'd6, 3'd1, 1, 3'd5, 3'd7, 0, 8'h18, 0, "R5");
        idle(8'h18, "R5");

        // R9: writes to status offsets are ignored
        step(0, 0, 0, 0, 0, 0, 1, 8'h10, 32'hFFFF_FFFF, "R9");
        step(0, 0, 0, 0, 0, 0, 1, 8'h1B, 32'h0000_0000, "R9");
        idle(8'h18, "R9");
        idle(8'h10, "R9");

        // R10: unmapped offsets read zero and ignore writes
        idle(8'h24, "R10"); idle(8'h00, "R10"); idle(8'h30, "R10"); idle(8'hFF, "R10");
        step(0, 0, 0, 0, 0, 0, 1, 8'h24, 32'h1234_5678, "R10");
        idle(8'h20, "R10");
        idle(8'h28, "R10");

        // R11: slot 7 requests have no effect
        step(1, 3'd7, 3'd0, 0, 0, 0, 0, 8'h10, 0, "R11");
        step(0, 0, 0, 1, 3'd7, 3'd7, 0, 8'h18, 0, "R11");
        idle(8'h10, "R11");
        idle(8'h18, "R11");

        // R4: mixed random traffic checked against the model
        for (int n = 0; n < 3000; n++) begin
            step(bit'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
                 bit'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
                 ($urandom_range(0, 3) == 0), addr_pool[$urandom_range(0, 11)],
                 $urandom(), "R4");
        end

        @(negedge clk);
        compare_now();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule